// File: doc/BRIEF.md
# Two-Way Translation Buffer with Access Protection

This block turns a 40-bit virtual byte address into a 36-bit physical address within the same clock cycle. The low 14 address bits select a byte inside a 16 KB page and pass through unchanged. The remaining 26 bits form the virtual page number. Eight of those bits pick one of 256 sets, and the other 18 bits are compared as a tag against both ways of that set at once. Each entry holds the tag, a 22-bit physical page number, a valid flag, a use flag, a dirty flag and two permission flags: writable, and user-accessible.

The processor presents each access with a write flag and a user-mode flag. When an access matches a valid entry and the entry's permissions allow it, `hit` rises and the physical address is driven. The next clock edge then records the access in the entry's status flags and in the set's least-recently-used bit. When the access matches but breaks a permission, `fault` rises instead, and no state changes. A separate miss handler does the page-table walk outside this block. It uses a victim readout port to learn which way to replace and what that way holds, including the use and dirty flags it must write back. It uses a fill port to install the new translation.

Top module: `xlate_tlb`

## Requirements
- R1: After reset, no entry is valid: every access misses (`hit`=0, `fault`=0, `paddr`=0), and the victim port reports `victim_valid`=0 and `victim_way`=0 for any set.
- R2: An access with `req_valid`=1 whose tag matches a valid entry in either way of its set, and whose permissions allow it, drives `hit`=1 in the same cycle.
- R3: The set index is `req_vaddr[21:14]` and the tag is `req_vaddr[39:22]`. On a hit, `paddr` is the entry's 22-bit page number placed above `req_vaddr[13:0]`.
- R4: On the clock edge that ends a hit, the entry's use flag is set. A write hit also sets its dirty flag. Both flags are read back through `victim_use` and `victim_dirty`.
- R5: A matching access that writes to an entry whose writable flag is 0, or that runs in user mode against an entry whose user flag is 0, gives `fault`=1, `hit`=0 and `paddr`=0. It leaves the use flag, the dirty flag and the set's LRU bit unchanged.
- R6: Each hit sets the set's LRU bit to the other way. The victim way is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way the LRU bit names.
- R7: `fill_en` installs `fill_vpn`, `fill_ppn` and the permission flags into `fill_way` of set `fill_vpn[7:0]` (tag `fill_vpn[25:8]`). The entry becomes valid with use and dirty cleared, and the set's LRU bit points away from the filled way. When a fill and a hit land in the same set in the same cycle, the fill decides the LRU bit.
- R8: With `req_valid`=0, `hit` and `fault` stay 0 and no status flag or LRU bit changes.
- R9: An access whose tag matches no valid entry of its set gives `hit`=0, `fault`=0 and `paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears valid, use, dirty and LRU state |
| req_valid | input | 1 | An access is presented this cycle |
| req_vaddr | input | 40 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| hit | output | 1 | Translation found and allowed |
| fault | output | 1 | Translation found but the access breaks its permissions |
| paddr | output | 36 | Physical address on a hit, zero otherwise |
| victim_index | input | 8 | Set examined by the miss handler |
| victim_way | output | 1 | Way chosen for replacement in that set |
| victim_valid | output | 1 | Chosen way holds a valid entry |
| victim_tag | output | 18 | Tag of the chosen way |
| victim_ppn | output | 22 | Physical page number of the chosen way |
| victim_use | output | 1 | Use flag of the chosen way (0 when invalid) |
| victim_dirty | output | 1 | Dirty flag of the chosen way (0 when invalid) |
| fill_en | input | 1 | Install an entry at the next clock edge |
| fill_way | input | 1 | Way to install into |
| fill_vpn | input | 26 | Virtual page number of the new entry |
| fill_ppn | input | 22 | Physical page number of the new entry |
| fill_writable | input | 1 | New entry allows writes |
| fill_user | input | 1 | New entry allows user-mode access |

## Verification
The assertions check four things on every cycle. `hit` and `fault` are never both high. Both stay low when no access is presented. A hit always carries the page offset through unchanged. An access that hit, repeated unchanged in the next cycle with no fill in between, gets the same verdict. The bench scenarios cover the rest: that use and dirty flags appear only after the right kind of hit and never after a fault, how the LRU bit moves when hits and fills alternate, that invalid ways are preferred as victims, and that a fill overrides a hit in the same set and cycle. Each of these needs a particular fill history before it can be observed.

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int IDX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_vaddr,
  input  logic                        req_write,
  input  logic                        req_user,
  output logic                        hit,
  output logic                        fault,
  output logic [PA_W-1:0]             paddr,
  input  logic [IDX_W-1:0]            victim_index,
  output logic                        victim_way,
  output logic                        victim_valid,
  output logic [VA_W-OFF_W-IDX_W-1:0] victim_tag,
  output logic [PA_W-OFF_W-1:0]       victim_ppn,
  output logic                        victim_use,
  output logic                        victim_dirty,
  input  logic                        fill_en,
  input  logic                        fill_way,
  input  logic [VA_W-OFF_W-1:0]       fill_vpn,
  input  logic [PA_W-OFF_W-1:0]       fill_ppn,
  input  logic                        fill_writable,
  input  logic                        fill_user
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int SETS  = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q  [2][SETS];
  logic [PPN_W-1:0] ppn_q  [2][SETS];
  logic [1:0]       perm_q [2][SETS];
  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  use_q [2];
  logic [SETS-1:0]  dty_q [2];
  logic [SETS-1:0]  lru_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  logic [1:0]       match;
  logic             sel;
  logic [1:0]       sel_perm;
  logic             viol;
  logic             found;

  assign idx   = req_vaddr[OFF_W +: IDX_W];
  assign tag   = req_vaddr[VA_W-1 -: TAG_W];
  assign f_idx = fill_vpn[IDX_W-1:0];
  assign f_tag = fill_vpn[VPN_W-1 -: TAG_W];

  always_comb begin
    for (int w = 0; w < 2; w++)
      match[w] = vld_q[w][idx] && (tag_q[w][idx] == tag);
  end

  assign sel      = ~match[0];
  assign found    = req_valid && (match != 2'b00);
  assign sel_perm = perm_q[sel][idx];
  assign viol     = (req_write && !sel_perm[0]) || (req_user && !sel_perm[1]);
  assign hit      = found && !viol;
  assign fault    = found && viol;
  assign paddr    = hit ? {ppn_q[sel][idx], req_vaddr[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_way][f_idx]  <= f_tag;
      ppn_q[fill_way][f_idx]  <= fill_ppn;
      perm_q[fill_way][f_idx] <= {fill_user, fill_writable};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      use_q[0] <= '0;
      use_q[1] <= '0;
      dty_q[0] <= '0;
      dty_q[1] <= '0;
      lru_q    <= '0;
    end else begin
      if (hit) begin
        use_q[sel][idx] <= 1'b1;
        if (req_write) dty_q[sel][idx] <= 1'b1;
        lru_q[idx] <= ~sel;
      end
      if (fill_en) begin
        vld_q[fill_way][f_idx] <= 1'b1;
        use_q[fill_way][f_idx] <= 1'b0;
        dty_q[fill_way][f_idx] <= 1'b0;
        lru_q[f_idx]           <= ~fill_way;
      end
    end
  end

  logic v0, v1;
  assign v0 = vld_q[0][victim_index];
  assign v1 = vld_q[1][victim_index];

  assign victim_way   = !v0 ? 1'b0 : (!v1 ? 1'b1 : lru_q[victim_index]);
  assign victim_valid = vld_q[victim_way][victim_index];
  assign victim_tag   = tag_q[victim_way][victim_index];
  assign victim_ppn   = ppn_q[victim_way][victim_index];
  assign victim_use   = victim_valid && use_q[victim_way][victim_index];
  assign victim_dirty = victim_valid && dty_q[victim_way][victim_index];
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int IDX_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_write,
  input logic            req_user,
  input logic            hit,
  input logic            fault,
  input logic [PA_W-1:0] paddr,
  input logic            fill_en
);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && fault));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!hit && !fault));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]));

  p_repeat_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fill_en) ##1 (req_valid && $stable(req_vaddr) && $stable(req_write)
      && $stable(req_user)) |-> hit);

  p_repeat_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fill_en) ##1 (req_valid && $stable(req_vaddr) && $stable(req_write)
      && $stable(req_user)) |-> fault);
endmodule

bind xlate_tlb xlate_tlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_write(req_write), .req_user(req_user), .hit(hit), .fault(fault),
  .paddr(paddr), .fill_en(fill_en)
);

// File: tb/xlate_tlb_test.sv
`timescale 1ns/1ps
module xlate_tlb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [39:0] req_vaddr = '0;
  logic hit, fault;
  logic [35:0] paddr;
  logic [7:0] victim_index = '0;
  logic victim_way, victim_valid, victim_use, victim_dirty;
  logic [17:0] victim_tag;
  logic [21:0] victim_ppn;
  logic fill_en = 1'b0, fill_way = 1'b0, fill_writable = 1'b0, fill_user = 1'b0;
  logic [25:0] fill_vpn = '0;
  logic [21:0] fill_ppn = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xlate_tlb uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .hit(hit), .fault(fault),
    .paddr(paddr), .victim_index(victim_index), .victim_way(victim_way),
    .victim_valid(victim_valid), .victim_tag(victim_tag), .victim_ppn(victim_ppn),
    .victim_use(victim_use), .victim_dirty(victim_dirty), .fill_en(fill_en),
    .fill_way(fill_way), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_writable(fill_writable), .fill_user(fill_user)
  );

  // {tag, index, offset, write, user, exp_hit, exp_fault, exp_paddr}
  localparam logic [79:0] VEC [10] = '{
    {18'h2A5A5, 8'h05, 14'h1234, 1'b0, 1'b1, 1'b1, 1'b0, 22'h12345, 14'h1234},
    {18'h2A5A5, 8'h05, 14'h3FFF, 1'b1, 1'b1, 1'b1, 1'b0, 22'h12345, 14'h3FFF},
    {18'h00001, 8'h05, 14'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 22'h3FFFF, 14'h0000},
    {18'h00001, 8'h05, 14'h0040, 1'b1, 1'b0, 1'b0, 1'b1, 36'h0},
    {18'h3FFFF, 8'hFF, 14'h2AAA, 1'b0, 1'b0, 1'b1, 1'b0, 22'h00ABC, 14'h2AAA},
    {18'h3FFFF, 8'hFF, 14'h2AAA, 1'b0, 1'b1, 1'b0, 1'b1, 36'h0},
    {18'h3FFFF, 8'hFF, 14'h0001, 1'b1, 1'b0, 1'b1, 1'b0, 22'h00ABC, 14'h0001},
    {18'h00002, 8'h05, 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},
    {18'h2A5A5, 8'h06, 14'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},
    {18'h2A5A5, 8'hFF, 14'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic fill(input logic w, input logic [17:0] t, input logic [7:0] i,
                      input logic [21:0] p, input logic wr, input logic us);
    fill_en = 1'b1; fill_way = w; fill_vpn = {t, i}; fill_ppn = p;
    fill_writable = wr; fill_user = us;
    step();
    fill_en = 1'b0;
  endtask

  task automatic access(input logic v, input logic [17:0] t, input logic [7:0] i,
                        input logic [13:0] o, input logic wr, input logic us);
    req_valid = v; req_vaddr = {t, i, o}; req_write = wr; req_user = us;
    #0.5;
  endtask

  task automatic victim(input logic [7:0] i);
    victim_index = i;
    #0.5;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: empty after reset
    access(1'b1, 18'h2A5A5, 8'h05, 14'h0, 1'b0, 1'b0);
    chk("R1 hit after reset", hit, 0);
    chk("R1 fault after reset", fault, 0);
    victim(8'h05);
    chk("R1 victim_valid", victim_valid, 0);
    chk("R1 victim_way", victim_way, 0);
    rst_n = 1'b1;
    req_valid = 1'b0;
    step();

    fill(1'b0, 18'h2A5A5, 8'h05, 22'h12345, 1'b1, 1'b1);
    fill(1'b1, 18'h00001, 8'h05, 22'h3FFFF, 1'b0, 1'b1);
    fill(1'b0, 18'h3FFFF, 8'hFF, 22'h00ABC, 1'b1, 1'b0);

    // R2 R3 R5 R9: vector table
    for (int k = 0; k < 10; k++) begin
      access(1'b1, VEC[k][79:62], VEC[k][61:54], VEC[k][53:40], VEC[k][39], VEC[k][38]);
      chk($sformatf("R2/R9 hit vec %0d", k), hit, VEC[k][37]);
      chk($sformatf("R5 fault vec %0d", k), fault, VEC[k][36]);
      chk($sformatf("R3 paddr vec %0d", k), paddr, VEC[k][35:0]);
      step();
    end
    req_valid = 1'b0;

    // R4 R6: set 05 both valid, LRU names way 0
    victim(8'h05);
    chk("R6 victim way lru", victim_way, 0);
    chk("R3 victim tag", victim_tag, 18'h2A5A5);
    chk("R7 victim ppn", victim_ppn, 22'h12345);
    chk("R4 use after read hit", victim_use, 1);
    chk("R4 dirty after write hit", victim_dirty, 1);
    // R6: invalid way preferred
    victim(8'hFF);
    chk("R6 invalid way chosen", victim_way, 1);
    chk("R6 invalid way valid flag", victim_valid, 0);

    access(1'b1, 18'h2A5A5, 8'h05, 14'h0, 1'b0, 1'b0);
    step();
    victim(8'h05);
    chk("R6 lru after way0 hit", victim_way, 1);
    chk("R4 way1 use", victim_use, 1);
    chk("R5 no dirty after fault", victim_dirty, 0);

    access(1'b1, 18'h00001, 8'h05, 14'h0, 1'b1, 1'b0);
    chk("R5 fault on read-only write", fault, 1);
    step();
    chk("R5 lru unchanged by fault", victim_way, 1);
    chk("R5 dirty unchanged by fault", victim_dirty, 0);

    access(1'b1, 18'h00001, 8'h05, 14'h0, 1'b0, 1'b1);
    step();
    req_valid = 1'b0;
    chk("R6 lru after way1 hit", victim_way, 0);

    // R8: idle request changes nothing
    fill(1'b0, 18'h00100, 8'h10, 22'h00777, 1'b1, 1'b1);
    access(1'b0, 18'h00100, 8'h10, 14'h5, 1'b1, 1'b0);
    chk("R8 hit idle", hit, 0);
    chk("R8 fault idle", fault, 0);
    step();
    fill(1'b1, 18'h00200, 8'h10, 22'h00888, 1'b1, 1'b1);
    victim(8'h10);
    chk("R7 lru away from filled way", victim_way, 0);
    chk("R8 use untouched", victim_use, 0);
    chk("R8 dirty untouched", victim_dirty, 0);

    // R7: fill and hit in the same set and cycle
    access(1'b1, 18'h00200, 8'h10, 14'h0, 1'b0, 1'b0);
    chk("R2 hit during fill", hit, 1);
    fill(1'b0, 18'h00300, 8'h10, 22'h00999, 1'b1, 1'b1);
    req_valid = 1'b0;
    chk("R7 fill wins lru", victim_way, 1);
    chk("R4 hit use kept in other way", victim_use, 1);
    access(1'b1, 18'h00300, 8'h10, 14'h0ABC, 1'b0, 1'b1);
    chk("R7 new entry hits", hit, 1);
    chk("R7 new entry paddr", paddr, {22'h00999, 14'h0ABC});
    step();
    req_valid = 1'b0;

    // R7: refill clears use and dirty
    fill(1'b1, 18'h00003, 8'h05, 22'h11111, 1'b1, 1'b1);
    access(1'b1, 18'h2A5A5, 8'h05, 14'h0, 1'b0, 1'b0);
    step();
    req_valid = 1'b0;
    victim(8'h05);
    chk("R7 refilled way chosen", victim_way, 1);
    chk("R7 refilled tag", victim_tag, 18'h00003);
    chk("R7 refill clears use", victim_use, 0);
    chk("R7 refill clears dirty", victim_dirty, 0);

    summary();
  end
endmodule